// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns two quadrature channels from a rotary or linear encoder into a signed-direction position. Each legal edge on either channel (4x decoding) moves an internal position counter by one. The channels first pass through a synchronizer. A registered compare of the current and previous channel levels then yields a step and its direction. The count itself updates one clock after that decision.

Alongside the count, the block drives three signals for an external counter chain. A count pulse lasts the low half of the clock in the cycle the counter moves. A cascade pulse has the same shape and fires only when the counter wraps. A direction level is valid from one clock before the counter update. The outputs never stall and have no handshake.

Top module: `quad_decoder_top`

## Requirements
- R1: While `rst` is high, `position` is 0, `dirUp` is 0 and both pulse outputs are 0.
- R2: With the channel state written {chanA,chanB}, the order 00→10→11→01→00 counts up by one per change and the reverse order counts down by one per change.
- R3: A single-channel change applied before clock edge e1 updates `position` at edge e1+3, which is two synchronizer stages plus one decode register.
- R4: `dirUp` takes the direction of a step (1 = up) at the clock edge one cycle before that step's counter update. It keeps that value until a later step is decoded.
- R5: In the cycle after each counter update, `countPulse` is high only while `clk` is low. It is low while `clk` is high and in every cycle without an update.
- R6: The counter wraps from 0xFFFF to 0 when counting up and from 0 to 0xFFFF when counting down. `cascadePulse` shows the same half-clock shape as `countPulse`, but only for a wrapping update.
- R7: A transition in which both channels change at once is ignored. `position` and `dirUp` do not move for it.
- R8: With no channel change, `position`, `dirUp` and both pulse outputs hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| chanA | input | 1 | Quadrature channel A, asynchronous |
| chanB | input | 1 | Quadrature channel B, asynchronous |
| position | output | 16 | Position counter |
| countPulse | output | 1 | Half-clock pulse per counter update |
| cascadePulse | output | 1 | Half-clock pulse per wrap |
| dirUp | output | 1 | Direction of the latest step, 1 = up |

## Verification
The bench keeps a five-deep history of the channel levels captured at each rising edge. A step decoded between the entries four and three edges old moves the expected count and sets the expected pulses. The entries three and two edges old set the expected direction, which matches the three-edge latency of R3 and the one-cycle direction lead of R4. All four outputs are compared one time unit after each falling edge, while the pulses should be visible. Both pulses are compared again just after each rising edge, where they must be low.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef struct packed {
    logic step;
    logic up;
  } stepStrobe_t;
endpackage

// File: rtl/qd_control.sv
module qd_control
  import qd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        chanA,
  input  logic        chanB,
  output stepStrobe_t strobe,
  output logic        dirUp
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] aSync, bSync;
  logic aPrev, bPrev;
  logic aNow, bNow;
  logic chgA, chgB, stepValid, stepUp;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          aSync <= '0;
          bSync <= '0;
        end else begin
          aSync <= {aSync[LAST-1:0], chanA};
          bSync <= {bSync[LAST-1:0], chanB};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          aSync <= '0;
          bSync <= '0;
        end else begin
          aSync <= chanA;
          bSync <= chanB;
        end
      end
    end
  endgenerate

  assign aNow = aSync[LAST];
  assign bNow = bSync[LAST];

  assign chgA      = aNow ^ aPrev;
  assign chgB      = bNow ^ bPrev;
  assign stepValid = chgA ^ chgB;
  assign stepUp    = aNow ^ bPrev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      aPrev  <= 1'b0;
      bPrev  <= 1'b0;
      strobe <= '0;
      dirUp  <= 1'b0;
    end else begin
      aPrev       <= aNow;
      bPrev       <= bNow;
      strobe.step <= stepValid;
      strobe.up   <= stepUp;
      if (stepValid) dirUp <= stepUp;
    end
  end

  // R7: a double change never produces a step
  a_r7_double_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(aNow) != $past(aPrev) && $past(bNow) != $past(bPrev)) |-> !strobe.step);

  // R4: direction only moves together with a decoded step
  a_r4_dir_sticky: assert property (@(posedge clk) disable iff (rst)
    !strobe.step |-> $stable(dirUp));
endmodule

// File: rtl/qd_datapath.sv
module qd_datapath
  import qd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  stepStrobe_t      strobe,
  input  logic             dirUp,
  output logic [WIDTH-1:0] position,
  output logic             countPulse,
  output logic             cascadePulse
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic countFlag, cascadeFlag, wrapNext;

  assign wrapNext = strobe.up ? (position == TOP) : (position == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      position    <= '0;
      countFlag   <= 1'b0;
      cascadeFlag <= 1'b0;
    end else begin
      countFlag   <= strobe.step;
      cascadeFlag <= strobe.step & wrapNext;
      if (strobe.step) position <= strobe.up ? position + 1'b1 : position - 1'b1;
    end
  end

  // half-clock pulses: registered flag gated with the low clock phase
  assign countPulse   = countFlag & ~clk;
  assign cascadePulse = cascadeFlag & ~clk;

  // R8: without a flagged update the count holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !countFlag |-> $stable(position));

  // R4: the direction seen one cycle before the update matches the move
  a_r4_dir_lead: assert property (@(posedge clk) disable iff (rst)
    countFlag |-> ($past(dirUp) == (position == $past(position) + 1'b1)));

  // R6: cascade only on a wrap
  a_r6_wrap_only: assert property (@(posedge clk) disable iff (rst)
    cascadeFlag |-> ((position == '0 && $past(position) == TOP) ||
                     (position == TOP && $past(position) == '0)));

  // R6: cascade always accompanies a count
  a_r6_cas_with_count: assert property (@(posedge clk) disable iff (rst)
    cascadeFlag |-> countFlag);

  // R2: each update moves by exactly one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    countFlag |-> (position == $past(position) + 1'b1 || position == $past(position) - 1'b1));
endmodule

// File: rtl/quad_decoder_top.sv
module quad_decoder_top
  import qd_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chanA,
  input  logic             chanB,
  output logic [WIDTH-1:0] position,
  output logic             countPulse,
  output logic             cascadePulse,
  output logic             dirUp
);
  stepStrobe_t strobe;

  qd_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .chanA(chanA), .chanB(chanB),
    .strobe(strobe), .dirUp(dirUp)
  );

  qd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dirUp(dirUp),
    .position(position), .countPulse(countPulse), .cascadePulse(cascadePulse)
  );
endmodule

// File: tb/quad_decoder_top_tb.sv
module quad_decoder_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chanA = 1'b0, chanB = 1'b0;
  logic [15:0] position;
  logic countPulse, cascadePulse, dirUp;

  int vectors = 0, fails = 0, cycles = 0;
  logic [1:0] hist [5];
  int expPos = 0;
  bit expDir = 0, expCnt = 0, expCas = 0;

  quad_decoder_top u_dut (
    .clk(clk), .rst(rst), .chanA(chanA), .chanB(chanB),
    .position(position), .countPulse(countPulse),
    .cascadePulse(cascadePulse), .dirUp(dirUp)
  );

  always #5 clk = ~clk;

  // gray index: 00->0, 10->1, 11->2, 01->3
  function automatic int gidx(logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // +1 up, -1 down, 0 none or invalid
  function automatic int move(logic [1:0] from, logic [1:0] to);
    int d = (gidx(to) - gidx(from) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) hist[i] = 2'b00;
      expPos = 0; expDir = 0; expCnt = 0; expCas = 0;
    end else begin
      int m, md;
      for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {chanA, chanB};
      m  = move(hist[4], hist[3]);
      md = move(hist[3], hist[2]);
      expCnt = (m != 0);
      expCas = (m == 1 && expPos == 65535) || (m == -1 && expPos == 0);
      expPos = (expPos + m + 65536) % 65536;
      if (md != 0) expDir = (md == 1);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // low phase: full compare (R2 R3 R4 R5 R6 R8, R1 during reset)
  always @(negedge clk) begin
    #1;
    if (rst) begin
      check(position == 0, "R1", "position", position, 0);
      check(dirUp == 0 && countPulse == 0 && cascadePulse == 0, "R1", "outputs",
            {dirUp, countPulse, cascadePulse}, 0);
    end else begin
      check(position == expPos[15:0], "R2/R3", "position", position, expPos);
      check(dirUp == expDir, "R4", "dirUp", dirUp, expDir);
      check(countPulse == expCnt, "R5", "countPulse", countPulse, expCnt);
      check(cascadePulse == expCas, "R6", "cascadePulse", cascadePulse, expCas);
    end
  end

  // high phase: pulses must be low (R5)
  always @(posedge clk) begin
    #2;
    check(countPulse == 0 && cascadePulse == 0, "R5", "pulses high phase",
          {countPulse, cascadePulse}, 0);
  end

  task automatic setAB(logic a, logic b, int wait_cycles);
    @(negedge clk);
    chanA = a; chanB = b;
    repeat (wait_cycles - 1) @(negedge clk);
  endtask

  task automatic stepUp(int n, int gap);
    for (int i = 0; i < n; i++) begin
      logic [1:0] s = {chanA, chanB};
      case (s)
        2'b00: setAB(1, 0, gap);
        2'b10: setAB(1, 1, gap);
        2'b11: setAB(0, 1, gap);
        default: setAB(0, 0, gap);
      endcase
    end
  endtask

  task automatic stepDown(int n, int gap);
    for (int i = 0; i < n; i++) begin
      logic [1:0] s = {chanA, chanB};
      case (s)
        2'b00: setAB(0, 1, gap);
        2'b01: setAB(1, 1, gap);
        2'b11: setAB(1, 0, gap);
        default: setAB(0, 0, gap);
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    stepDown(1, 6);           // R6 underflow 0 -> FFFF
    stepUp(1, 6);             // R6 overflow FFFF -> 0
    stepUp(10, 3);            // R2 up, spaced
    stepDown(7, 4);           // R2 down, R4 direction change
    stepUp(12, 1);            // back-to-back steps
    stepDown(12, 1);
    setAB(~chanA, ~chanB, 8); // R7 double change ignored
    setAB(~chanA, ~chanB, 8); // R7 again
    repeat (10) @(negedge clk); // R8 idle hold
    stepUp(3, 1);
    stepDown(1, 1);
    stepUp(1, 2);
    stepDown(20, 2);          // R3 latency under reversals
    repeat (8) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule